// File: doc/BRIEF.md
# PTP Event Frame Timestamp Classifier

This block watches Ethernet frame bytes as they stream through a byte-wide path, one byte per accepted cycle, with start and end markers. It decides whether each frame is a precision-time event message whose ingress or egress instant should be captured. When it is, the block raises a one-cycle capture strobe and reports the message type that was found. The frame layout it expects is an untagged layer-2 header of `L2_LEN` bytes, then a 20-byte IPv4 header with no options, then an 8-byte UDP header, then the PTP header.

A channel's configuration picks the protocol generation (version 1 or version 2) and, for version 1, a role bit and a direction-swap bit. These settle which of Sync and Delay_Req is captured on receive and which on transmit. For version 2 there is a flag that accepts every message type. A user-match mode replaces all of these rules with a single comparison: the frame qualifies when the byte at a programmable index equals a programmable value.

The configuration and the direction input are sampled with the first byte of each frame and held until the next frame starts. A decision therefore always uses one consistent set of settings.

Top module: `ptp_event_classifier`

## Requirements
- R1: With user-match off, a frame qualifies only if the byte at index `L2_LEN` (the first IPv4 byte) equals 0x45.
- R2: With user-match off, a frame qualifies only if the byte at index `L2_LEN+9` (the IPv4 protocol) equals 0x11.
- R3: With user-match off, a frame qualifies only if the bytes at `L2_LEN+22` and `L2_LEN+23` (the UDP destination port, high byte first) are 0x01 and 0x3F.
- R4: The message type comes from one of two places. In version-2 mode it is the low nibble of the byte at `L2_LEN+28`, and its high nibble is ignored. In version-1 mode it is the whole byte at `L2_LEN+60`, and a value with a non-zero high nibble matches no type. Type 0 is Sync and type 1 is Delay_Req. `ts_type` reports the low nibble.
- R5: In version-1 mode with `cfg_master`=0 and `cfg_tx_assert`=0, Sync qualifies only on receive (`in_dir_tx`=0) and Delay_Req only on transmit.
- R6: In version-1 mode with `cfg_master`=0 and `cfg_tx_assert`=1, Sync qualifies only on transmit and Delay_Req only on receive.
- R7: In version-1 mode with `cfg_master`=1, Sync and Delay_Req qualify in both directions whatever `cfg_tx_assert` holds, and other types never qualify.
- R8: In version-2 mode with `cfg_all_msgs`=0, Sync and Delay_Req qualify in both directions and every other type is rejected.
- R9: In version-2 mode with `cfg_all_msgs`=1, every message type qualifies in both directions.
- R10: With `cfg_user_en`=1, a frame qualifies exactly when the byte at index `cfg_user_off` equals `cfg_user_val`, whatever the header checks give. `ts_type` is then the low nibble of that byte.
- R11: `ts_pulse` is high for exactly one cycle, the cycle after the deciding byte is accepted, and at most once per frame. There is no pulse if the end marker comes before the deciding byte.
- R12: All `cfg_*` inputs and `in_dir_tx` are sampled with the start byte of a frame. Changing them later in the same frame has no effect on that frame.
- R13: After reset `ts_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_dir_tx | input | 1 | 1 for a transmitted frame, 0 for a received one |
| cfg_v2 | input | 1 | 1 selects version-2 parsing and rules |
| cfg_all_msgs | input | 1 | Version 2: accept every message type |
| cfg_master | input | 1 | Version 1: capture Sync and Delay_Req in both directions |
| cfg_tx_assert | input | 1 | Version 1 slave: swap the capture direction |
| cfg_user_en | input | 1 | Enable user byte-match mode |
| cfg_user_off | input | IDX_W | Frame byte index for user match |
| cfg_user_val | input | 8 | Byte value for user match |
| ts_pulse | output | 1 | One-cycle capture strobe |
| ts_type | output | 4 | Message type of the capture |

## Verification
The bench sweeps every combination of version, all-messages flag, role, swap bit and direction against four message types. A design that wired the swap bit or the role wrongly would capture Sync in the wrong direction, or would drop Delay_Req. Frames are then corrupted one header field at a time, including each half of the destination port, to catch a design that checked only some of the bytes. Further frames are cut short just before the deciding byte and exactly on it, so an off-by-one in the pulse timing or in early-end handling shows up. Configuration and direction are also flipped in the middle of a frame, which a design that failed to hold its settings would misclassify.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

  // Field positions relative to the first IPv4 byte
  localparam int OFF_VIHL    = 0;
  localparam int OFF_PROTO   = 9;
  localparam int OFF_DPORT_H = 22;
  localparam int OFF_DPORT_L = 23;
  localparam int OFF_PTP     = 28;
  localparam int V1_TYPE_OFF = 32;   // control byte inside the v1 header

  localparam logic [7:0]  IPV4_NOOPT = 8'h45;
  localparam logic [7:0]  PROTO_UDP  = 8'h11;
  localparam logic [15:0] EVENT_PORT = 16'h013F;

  localparam logic [3:0] TYPE_SYNC = 4'd0;
  localparam logic [3:0] TYPE_DREQ = 4'd1;

  // Capture policy for the header-parsing modes
  function automatic logic ptp_policy(
    input logic       v2,
    input logic       all_msgs,
    input logic       master,
    input logic       tx_assert,
    input logic       dir_tx,
    input logic       known,
    input logic [3:0] mtype
  );
    logic is_sync;
    logic is_dreq;
    is_sync = known && (mtype == TYPE_SYNC);
    is_dreq = known && (mtype == TYPE_DREQ);
    if (v2) begin
      return all_msgs ? known : (is_sync || is_dreq);
    end else if (master) begin
      return is_sync || is_dreq;
    end else begin
      return (is_sync && (dir_tx == tx_assert)) ||
             (is_dreq && (dir_tx != tx_assert));
    end
  endfunction

endpackage

// File: rtl/ptp_cfg_hold.sv
module ptp_cfg_hold #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             live_v2,
  input  logic             live_all,
  input  logic             live_master,
  input  logic             live_txa,
  input  logic             live_user,
  input  logic [IDX_W-1:0] live_off,
  input  logic [7:0]       live_val,
  input  logic             live_dir,
  output logic             eff_v2,
  output logic             eff_all,
  output logic             eff_master,
  output logic             eff_txa,
  output logic             eff_user,
  output logic [IDX_W-1:0] eff_off,
  output logic [7:0]       eff_val,
  output logic             eff_dir
);

  localparam int HW = IDX_W + 14;

  logic [HW-1:0] live_vec;
  logic [HW-1:0] held_q;
  logic [HW-1:0] eff_vec;

  assign live_vec = {live_v2, live_all, live_master, live_txa, live_user,
                     live_off, live_val, live_dir};

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (start) begin
      held_q <= live_vec;
    end
  end

  // The start byte itself is judged with the freshly sampled settings
  assign eff_vec = start ? live_vec : held_q;

  assign {eff_v2, eff_all, eff_master, eff_txa, eff_user,
          eff_off, eff_val, eff_dir} = eff_vec;

endmodule

// File: rtl/ptp_hdr_parse.sv
module ptp_hdr_parse
  import ptp_cls_pkg::*;
#(
  parameter int L2_LEN = 14,
  parameter int IDX_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             cfg_v2,
  input  logic [IDX_W-1:0] user_off,
  input  logic [7:0]       user_val,
  output logic             byte_take,
  output logic             evt_fire,
  output logic             evt_known,
  output logic [3:0]       evt_type,
  output logic             user_fire
);

  localparam logic [IDX_W-1:0] IX_VIHL  = IDX_W'(L2_LEN + OFF_VIHL);
  localparam logic [IDX_W-1:0] IX_PROTO = IDX_W'(L2_LEN + OFF_PROTO);
  localparam logic [IDX_W-1:0] IX_DPH   = IDX_W'(L2_LEN + OFF_DPORT_H);
  localparam logic [IDX_W-1:0] IX_DPL   = IDX_W'(L2_LEN + OFF_DPORT_L);
  localparam logic [IDX_W-1:0] IX_V2T   = IDX_W'(L2_LEN + OFF_PTP);
  localparam logic [IDX_W-1:0] IX_V1T   = IDX_W'(L2_LEN + OFF_PTP + V1_TYPE_OFF);
  localparam logic [IDX_W-1:0] IX_MAX   = {IDX_W{1'b1}};

  logic             active_q;
  logic             beyond_q;
  logic             ok_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] cur_idx;
  logic             cur_ok;
  logic             ok_base;
  logic             field_ok;
  logic [IDX_W-1:0] cls_idx;

  assign byte_take = in_valid && (in_sof || active_q);
  assign cur_idx   = in_sof ? '0 : idx_q;
  assign cur_ok    = in_sof || !beyond_q;
  assign ok_base   = in_sof ? 1'b1 : ok_q;
  assign cls_idx   = cfg_v2 ? IX_V2T : IX_V1T;

  always_comb begin
    field_ok = 1'b1;
    if (cur_ok) begin
      if (cur_idx == IX_VIHL)  field_ok = (in_data == IPV4_NOOPT);
      if (cur_idx == IX_PROTO) field_ok = (in_data == PROTO_UDP);
      if (cur_idx == IX_DPH)   field_ok = (in_data == EVENT_PORT[15:8]);
      if (cur_idx == IX_DPL)   field_ok = (in_data == EVENT_PORT[7:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      beyond_q <= 1'b0;
      ok_q     <= 1'b0;
      idx_q    <= '0;
    end else if (byte_take) begin
      active_q <= !in_eof;
      ok_q     <= ok_base && field_ok;
      if (cur_idx == IX_MAX) begin
        beyond_q <= 1'b1;
        idx_q    <= cur_idx;
      end else begin
        beyond_q <= 1'b0;
        idx_q    <= cur_idx + 1'b1;
      end
    end
  end

  assign evt_fire  = byte_take && cur_ok && (cur_idx == cls_idx) && ok_base;
  assign evt_type  = in_data[3:0];
  assign evt_known = cfg_v2 || (in_data[7:4] == 4'h0);
  assign user_fire = byte_take && cur_ok && (cur_idx == user_off) &&
                     (in_data == user_val);

  // Checker state: a header event may happen only once per frame
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else if (byte_take && in_sof) seen_q <= evt_fire;
    else if (evt_fire) seen_q <= 1'b1;
  end

  assert_single_event_R11: assert property (@(posedge clk) disable iff (rst)
    (evt_fire && !in_sof) |-> !seen_q);

endmodule

// File: rtl/ptp_evt_qualify.sv
module ptp_evt_qualify
  import ptp_cls_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_take,
  input  logic       cfg_v2,
  input  logic       cfg_all,
  input  logic       cfg_master,
  input  logic       cfg_txa,
  input  logic       cfg_user,
  input  logic       dir_tx,
  input  logic       evt_fire,
  input  logic       evt_known,
  input  logic [3:0] evt_type,
  input  logic       user_fire,
  output logic       ts_pulse,
  output logic [3:0] ts_type
);

  logic hit;

  always_comb begin
    if (cfg_user) hit = user_fire;
    else hit = evt_fire && ptp_policy(cfg_v2, cfg_all, cfg_master, cfg_txa,
                                      dir_tx, evt_known, evt_type);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_pulse <= 1'b0;
      ts_type  <= '0;
    end else begin
      ts_pulse <= hit;
      if (hit) ts_type <= evt_type;
    end
  end

  // Checker state: settings that applied to the byte behind the pulse
  logic c_v2, c_all, c_master, c_txa, c_user, c_dir;
  always_ff @(posedge clk) begin
    if (rst) begin
      {c_v2, c_all, c_master, c_txa, c_user, c_dir} <= '0;
    end else begin
      {c_v2, c_all, c_master, c_txa, c_user, c_dir} <=
        {cfg_v2, cfg_all, cfg_master, cfg_txa, cfg_user, dir_tx};
    end
  end

  assert_pulse_follows_byte_R11: assert property (@(posedge clk) disable iff (rst)
    ts_pulse |-> $past(byte_take));

  assert_v2_restricted_R8: assert property (@(posedge clk) disable iff (rst)
    (ts_pulse && c_v2 && !c_all && !c_user) |-> (ts_type <= TYPE_DREQ));

  assert_v1_slave_dir_R5: assert property (@(posedge clk) disable iff (rst)
    (ts_pulse && !c_v2 && !c_user && !c_master && !c_txa) |->
      (c_dir == (ts_type == TYPE_DREQ)));

  assert_v1_swap_dir_R6: assert property (@(posedge clk) disable iff (rst)
    (ts_pulse && !c_v2 && !c_user && !c_master && c_txa) |->
      (c_dir == (ts_type == TYPE_SYNC)));

endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier #(
  parameter int L2_LEN = 14,
  parameter int IDX_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_dir_tx,
  input  logic             cfg_v2,
  input  logic             cfg_all_msgs,
  input  logic             cfg_master,
  input  logic             cfg_tx_assert,
  input  logic             cfg_user_en,
  input  logic [IDX_W-1:0] cfg_user_off,
  input  logic [7:0]       cfg_user_val,
  output logic             ts_pulse,
  output logic [3:0]       ts_type
);

  logic             start;
  logic             e_v2, e_all, e_master, e_txa, e_user, e_dir;
  logic [IDX_W-1:0] e_off;
  logic [7:0]       e_val;
  logic             byte_take, evt_fire, evt_known, user_fire;
  logic [3:0]       evt_type;

  assign start = in_valid && in_sof;

  ptp_cfg_hold #(.IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst(rst), .start(start),
    .live_v2(cfg_v2), .live_all(cfg_all_msgs), .live_master(cfg_master),
    .live_txa(cfg_tx_assert), .live_user(cfg_user_en), .live_off(cfg_user_off),
    .live_val(cfg_user_val), .live_dir(in_dir_tx),
    .eff_v2(e_v2), .eff_all(e_all), .eff_master(e_master), .eff_txa(e_txa),
    .eff_user(e_user), .eff_off(e_off), .eff_val(e_val), .eff_dir(e_dir)
  );

  ptp_hdr_parse #(.L2_LEN(L2_LEN), .IDX_W(IDX_W)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_v2(e_v2),
    .user_off(e_off), .user_val(e_val),
    .byte_take(byte_take), .evt_fire(evt_fire), .evt_known(evt_known),
    .evt_type(evt_type), .user_fire(user_fire)
  );

  ptp_evt_qualify u_qual (
    .clk(clk), .rst(rst), .byte_take(byte_take),
    .cfg_v2(e_v2), .cfg_all(e_all), .cfg_master(e_master), .cfg_txa(e_txa),
    .cfg_user(e_user), .dir_tx(e_dir),
    .evt_fire(evt_fire), .evt_known(evt_known), .evt_type(evt_type),
    .user_fire(user_fire), .ts_pulse(ts_pulse), .ts_type(ts_type)
  );

endmodule

// File: tb/tb_ptp_event_classifier.sv
`timescale 1ns/1ps
module tb_ptp_event_classifier;

  localparam int L2 = 14;
  localparam int V2IX = L2 + 28;
  localparam int V1IX = L2 + 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_dir_tx = 0;
  logic [7:0] in_data = '0;
  logic cfg_v2 = 0, cfg_all_msgs = 0, cfg_master = 0, cfg_tx_assert = 0, cfg_user_en = 0;
  logic [7:0] cfg_user_off = '0, cfg_user_val = '0;
  logic ts_pulse;
  logic [3:0] ts_type;

  always #4 clk = ~clk;

  ptp_event_classifier #(.L2_LEN(L2), .IDX_W(8)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_dir_tx(in_dir_tx),
    .cfg_v2(cfg_v2), .cfg_all_msgs(cfg_all_msgs), .cfg_master(cfg_master),
    .cfg_tx_assert(cfg_tx_assert), .cfg_user_en(cfg_user_en),
    .cfg_user_off(cfg_user_off), .cfg_user_val(cfg_user_val),
    .ts_pulse(ts_pulse), .ts_type(ts_type)
  );

  int total = 0, bad = 0;
  logic [7:0] fb [0:95];
  int npulse, pidx;
  logic [3:0] ptype;
  bit flip_all = 0, flip_dir = 0;

  task automatic sample(input int k);
    if (ts_pulse) begin
      npulse++; pidx = k; ptype = ts_type;
    end
  endtask

  task automatic send_frame(input int len);
    npulse = 0; pidx = -1; ptype = 4'h0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      sample(k - 1);
      in_valid = 1; in_data = fb[k]; in_sof = (k == 0); in_eof = (k == len - 1);
      if (k == 1) begin
        if (flip_all) cfg_all_msgs = !cfg_all_msgs;
        if (flip_dir) in_dir_tx = !in_dir_tx;
      end
    end
    @(negedge clk);
    sample(len - 1);
    in_valid = 0; in_sof = 0; in_eof = 0;
    @(negedge clk);
    sample(len);
  endtask

  task automatic check(input string tag, input bit exp, input int eidx, input logic [3:0] etype);
    bit ok;
    total++;
    ok = exp ? (npulse == 1 && pidx == eidx && ptype == etype) : (npulse == 0);
    if (!ok) begin
      bad++;
      $display("FAIL %s: pulses=%0d idx=%0d type=%0h expected hit=%0d idx=%0d type=%0h",
               tag, npulse, pidx, ptype, exp, eidx, etype);
    end
  endtask

  task automatic build(input logic [3:0] t);
    for (int i = 0; i < 96; i++) fb[i] = 8'(i * 7 + 3);
    fb[L2] = 8'h45; fb[L2 + 9] = 8'h11;
    fb[L2 + 22] = 8'h01; fb[L2 + 23] = 8'h3F;
    fb[V2IX] = {4'hA, t};
    fb[V1IX] = {4'h0, t};
    if (fb[L2 + 28] == 8'h00) fb[L2 + 28] = 8'hA0;
  endtask

  function automatic bit model(input bit v2, input bit all, input bit m, input bit txa,
                               input bit tx, input int t);
    if (v2) return all ? 1'b1 : (t < 2);
    if (t > 1) return 1'b0;
    if (m) return 1'b1;
    return (t == 0) ? (tx == txa) : (tx != txa);
  endfunction

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (ts_pulse !== 1'b0) begin
      bad++; $display("FAIL R13 reset: ts_pulse=%b expected 0", ts_pulse);
    end
    rst = 0;
    @(negedge clk);

    // R4..R9: full policy sweep over version, flags, direction and type
    for (int v = 0; v < 2; v++)
      for (int a = 0; a < 2; a++)
        for (int m = 0; m < 2; m++)
          for (int x = 0; x < 2; x++)
            for (int d = 0; d < 2; d++)
              for (int t = 0; t < 4; t++) begin
                cfg_v2 = v[0]; cfg_all_msgs = a[0]; cfg_master = m[0];
                cfg_tx_assert = x[0]; in_dir_tx = d[0];
                build(4'(t));
                send_frame(80);
                check($sformatf("R4-sweep R5 R6 R7 R8 R9 v2=%0d all=%0d m=%0d txa=%0d tx=%0d t=%0d",
                                v, a, m, x, d, t),
                      model(v[0], a[0], m[0], x[0], d[0], t), v ? V2IX : V1IX, 4'(t));
              end

    // R4: v1 control byte with non-zero high nibble matches nothing
    cfg_v2 = 0; cfg_master = 1; in_dir_tx = 0;
    build(4'h0); fb[V1IX] = 8'h10; send_frame(80);
    check("R4 v1 high nibble", 0, 0, 0);

    // Header field rejections in v2 accept-all mode
    cfg_v2 = 1; cfg_all_msgs = 1;
    build(4'h0); fb[L2] = 8'h46; send_frame(80);
    check("R1 vihl 0x46", 0, 0, 0);
    build(4'h0); fb[L2 + 9] = 8'h06; send_frame(80);
    check("R2 proto 0x06", 0, 0, 0);
    build(4'h0); fb[L2 + 22] = 8'h00; send_frame(80);
    check("R3 port high byte", 0, 0, 0);
    build(4'h0); fb[L2 + 23] = 8'h40; send_frame(80);
    check("R3 port low byte", 0, 0, 0);
    build(4'h5); send_frame(80);
    check("R9 control frame", 1, V2IX, 4'h5);

    // R11: early end and end exactly on the deciding byte
    build(4'h0); send_frame(V2IX);
    check("R11 ends before type byte", 0, 0, 0);
    build(4'h1); send_frame(V2IX + 1);
    check("R11 ends on type byte", 1, V2IX, 4'h1);

    // R10: user match overrides header checks
    cfg_user_en = 1; cfg_user_off = 8'd5; cfg_user_val = 8'hA7;
    build(4'h0); fb[L2] = 8'h00; fb[5] = 8'hA7; send_frame(80);
    check("R10 user match", 1, 5, 4'h7);
    build(4'h0); fb[5] = 8'hA6; send_frame(80);
    check("R10 user mismatch", 0, 0, 0);
    cfg_user_off = 8'd0; cfg_user_val = 8'hC3;
    build(4'h0); fb[0] = 8'hC3; send_frame(80);
    check("R10 user match on start byte", 1, 0, 4'h3);
    cfg_user_en = 0;

    // R12: mid-frame changes have no effect
    cfg_v2 = 1; cfg_all_msgs = 0; flip_all = 1;
    build(4'h2); send_frame(80);
    check("R12 all-msgs flipped mid-frame", 0, 0, 0);
    flip_all = 0;
    cfg_all_msgs = 0;
    cfg_v2 = 0; cfg_master = 0; cfg_tx_assert = 0; in_dir_tx = 0; flip_dir = 1;
    build(4'h0); send_frame(80);
    check("R12 direction flipped mid-frame", 1, V1IX, 4'h0);
    flip_dir = 0;

    finish_run();
  end

endmodule